// File: doc/BRIEF.md
# DRAM Refresh Interval Timer with CAS-before-RAS Sequencer

This block keeps a DRAM array alive. An 8-bit counter advances on a prescaled tick taken from the system clock. Each time the counter equals a programmable compare value at a tick, the counter returns to zero and a CAS-before-RAS refresh cycle is driven onto the active-low row and column strobes. Software programs the counter, the compare value and a control field through a small register port. The control field picks the tick rate or halts the timer, and sets how many wait states a refresh cycle holds.

Enabling the tick does not clear the counter. A counter that is already above the compare value therefore runs up to 0xFF, wraps to zero and reaches the compare value only after that. Writing zero to the counter before starting the timer gives a correct first interval. Wait states are added only from the configuration and never depend on an external wait pin. A match that arrives while a refresh is in progress is held in one pending slot. Any further matches during that refresh are lost.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: After reset, the counter, compare and control registers read 0, ras_n and cas_n are 1 and busy is 0.
- R2: With clock-select code 000 the counter holds its value and no refresh starts.
- R3: With a nonzero clock-select code the counter advances by one per tick, starting from the value it holds. With code 001 (divisor 2) this is exactly 10 steps in 20 clock cycles. A counter write in the same cycle as a tick takes priority.
- R4: At a tick where counter equals compare, the counter becomes 0 and busy rises on the next clock. Refreshes then repeat every (compare+1)×divisor cycles, with codes 001..111 giving divisors 2, 8, 32, 128, 512, 2048 and 4096.
- R5: A counter above the compare value when the timer starts wraps from 0xFF to 0x00 before its first match. No refresh occurs before that match.
- R6: The register address selects the target: 0 is the counter, 1 is the compare value and 2 is control. Control bits [2:0] hold the clock select, bit 3 is the long-pitch enable and bits [5:4] are the wait count. Reads return the stored value, and address 3 reads 0.
- R7: A refresh takes one state per clock. In order: both strobes high, then cas_n low with ras_n high, then both low, then both high in the completion state.
- R8: When long-pitch is 1, the wait count n (0..3) adds n states with both strobes low, so ras_n is low for 1+n cycles. When long-pitch is 0, no wait states are added whatever the wait count.
- R9: A match during a refresh is stored as one pending request, and its refresh starts in the cycle after the completion state. Further matches during the same refresh are dropped.
- R10: busy is high in every state of a refresh and only then, so for 4+n cycles, and cas_n is low only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| busy | output | 1 | High while a refresh cycle runs |

## Verification
The timer is run with the tick stopped, with the fastest tick from a low start value, from a start value above the compare value, and at four divisor and compare pairs. These runs separate holding, counting, wrap-before-match and the exact period formula. The strobe sequence is traced one cycle at a time with long-pitch off and with two wait states, and a run with long-pitch off and a nonzero wait count shows that the count is ignored. A compare value of zero at the fastest tick with the longest wait forces matches during every refresh. This shows back-to-back chaining, and stopping the timer shows that at most one request was queued.

// File: rtl/drf_pkg.sv
package drf_pkg;

    localparam int CNT_W   = 8;
    localparam int CKS_W   = 3;
    localparam int WAIT_W  = 2;
    localparam int PRE_W   = 12;
    localparam int ADDR_W  = 2;

    localparam logic [ADDR_W-1:0] ADDR_CNT  = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CMP  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd2;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_PRE,
        SEQ_CAS,
        SEQ_RAS,
        SEQ_WAIT,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic [WAIT_W-1:0] wait_cnt;
        logic              long_pitch;
        logic [CKS_W-1:0]  clk_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // number of low prescaler bits that must all be set for a tick
    function automatic int unsigned tap_shift(input int unsigned code);
        case (code)
            1:       return 1;
            2:       return 3;
            3:       return 5;
            4:       return 7;
            5:       return 9;
            6:       return 11;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/drf_prescaler.sv
module drf_prescaler
    import drf_pkg::*;
#(
    parameter int P_W = PRE_W,
    parameter int S_W = CKS_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [S_W-1:0] clk_sel,
    output logic           tick
);
    localparam int N_CODES = 2 ** S_W;

    logic [P_W-1:0]     pre_q;
    logic [N_CODES-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + 1'b1;
    end

    assign taps[0] = 1'b0;

    generate
        for (genvar g = 1; g < N_CODES; g++) begin : g_tap
            localparam int SH = tap_shift(g);
            assign taps[g] = &pre_q[SH-1:0];
        end
    endgenerate

    assign tick = taps[clk_sel];

endmodule

// File: rtl/drf_interval_counter.sv
module drf_interval_counter
    import drf_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         cnt_we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cmp,
    output logic [W-1:0] cnt_q,
    output logic         match
);
    assign match = tick && !cnt_we && (cnt_q == cmp);

    always_ff @(posedge clk) begin
        if (rst)         cnt_q <= '0;
        else if (cnt_we) cnt_q <= wdata;
        else if (match)  cnt_q <= '0;
        else if (tick)   cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/drf_cbr_seq.sv
module drf_cbr_seq
    import drf_pkg::*;
#(
    parameter int WW = WAIT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          long_pitch,
    input  logic [WW-1:0] wait_cnt,
    output logic          ras_n,
    output logic          cas_n,
    output logic          busy
);
    seq_state_e    state, nxt;
    logic          pend, pend_n, start;
    logic [WW-1:0] wt, wt_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            pend  <= 1'b0;
            wt    <= '0;
        end else begin
            state <= nxt;
            pend  <= pend_n;
            wt    <= wt_n;
        end
    end

    always_comb begin
        nxt    = state;
        pend_n = pend;
        wt_n   = wt;
        start  = 1'b0;
        case (state)
            SEQ_IDLE: if (req) start = 1'b1;
            SEQ_PRE:  nxt = SEQ_CAS;
            SEQ_CAS:  nxt = SEQ_RAS;
            SEQ_RAS, SEQ_WAIT: begin
                if (wt != '0) begin
                    nxt  = SEQ_WAIT;
                    wt_n = wt - 1'b1;
                end else begin
                    nxt = SEQ_DONE;
                end
            end
            SEQ_DONE: begin
                if (pend || req) begin
                    start  = 1'b1;
                    pend_n = pend && req;
                end else begin
                    nxt = SEQ_IDLE;
                end
            end
            default: nxt = SEQ_IDLE;
        endcase
        if (req && state != SEQ_IDLE && state != SEQ_DONE) pend_n = 1'b1;
        if (start) begin
            nxt  = SEQ_PRE;
            wt_n = long_pitch ? wait_cnt : '0;
        end
    end

    assign cas_n = !(state == SEQ_CAS || state == SEQ_RAS || state == SEQ_WAIT);
    assign ras_n = !(state == SEQ_RAS || state == SEQ_WAIT);
    assign busy  = (state != SEQ_IDLE);

endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl
    import drf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              ras_n,
    output logic              cas_n,
    output logic              busy
);
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt_q;
    ctrl_t            ctrl_q;
    logic [CKS_W-1:0] clk_sel;
    logic             cnt_we;
    logic             tick;
    logic             match;

    assign cnt_we  = wr_en && (wr_addr == ADDR_CNT);
    assign clk_sel = ctrl_q.clk_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_CMP)  cmp_q  <= wr_data;
            if (wr_addr == ADDR_CTRL) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
        end
    end

    always_comb begin
        case (rd_addr)
            ADDR_CNT:  rd_data = cnt_q;
            ADDR_CMP:  rd_data = cmp_q;
            ADDR_CTRL: rd_data = CNT_W'(ctrl_q);
            default:   rd_data = '0;
        endcase
    end

    drf_prescaler #(.P_W(PRE_W), .S_W(CKS_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .clk_sel (clk_sel),
        .tick    (tick)
    );

    drf_interval_counter #(.W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .cnt_we (cnt_we),
        .wdata  (wr_data),
        .cmp    (cmp_q),
        .cnt_q  (cnt_q),
        .match  (match)
    );

    drf_cbr_seq #(.WW(WAIT_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req        (match),
        .long_pitch (ctrl_q.long_pitch),
        .wait_cnt   (ctrl_q.wait_cnt),
        .ras_n      (ras_n),
        .cas_n      (cas_n),
        .busy       (busy)
    );

endmodule

// File: rtl/drf_checker.sv
module drf_checker
    import drf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cnt_we,
    input logic             tick,
    input logic             match,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] cmp_q,
    input logic [CKS_W-1:0] clk_sel,
    input logic             ras_n,
    input logic             cas_n,
    input logic             busy
);
    p_hold_stopped_r2: assert property (@(posedge clk) disable iff (rst)
        (clk_sel == '0 && !cnt_we) |=> $stable(cnt_q));

    p_step_per_tick_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && !cnt_we && cnt_q != cmp_q) |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

    p_clear_on_match_r4: assert property (@(posedge clk) disable iff (rst)
        match |=> cnt_q == '0);

    p_start_on_match_r4: assert property (@(posedge clk) disable iff (rst)
        (match && !busy) |=> busy);

    p_ras_needs_cas_r7: assert property (@(posedge clk) disable iff (rst)
        !ras_n |-> !cas_n);

    p_cas_before_ras_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(ras_n) |-> $past(!cas_n));

    p_cas_alone_first_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(cas_n) |-> ras_n);

    p_strobe_in_busy_r10: assert property (@(posedge clk) disable iff (rst)
        !cas_n |-> busy);

endmodule

bind dram_refresh_ctrl drf_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .cnt_we  (cnt_we),
    .tick    (tick),
    .match   (match),
    .cnt_q   (cnt_q),
    .cmp_q   (cmp_q),
    .clk_sel (clk_sel),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .busy    (busy)
);

// File: tb/dram_refresh_ctrl_test.sv
module dram_refresh_ctrl_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ras_n, cas_n, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int cas_falls = 0;
    logic prev_cas = 1'b1;

    dram_refresh_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ras_n(ras_n), .cas_n(cas_n), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (prev_cas && !cas_n) cas_falls++;
        prev_cas = cas_n;
    end

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d cycles, expected below 150000", cycles);
            summary();
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic wait_rise(output int n);
        logic pb;
        n = 0;
        pb = busy;
        while (n < 20000) begin
            @(negedge clk);
            n++;
            if (busy && !pb) break;
            pb = busy;
        end
    endtask

    task automatic measure(output int blen, output int rlen, output int clen);
        blen = 0; rlen = 0; clen = 0;
        while (busy && blen < 100) begin
            blen++;
            if (!ras_n) rlen++;
            if (!cas_n) clen++;
            @(negedge clk);
        end
    endtask

    task automatic setup(input logic [7:0] cnt, input logic [7:0] cmp, input logic [7:0] ctrl);
        wr(2'd2, 8'h00);
        wr(2'd1, cmp);
        wr(2'd0, cnt);
        wr(2'd2, ctrl);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); check(d == 0, "R1 counter", d, 0);
        rd(2'd1, d); check(d == 0, "R1 compare", d, 0);
        rd(2'd2, d); check(d == 0, "R1 control", d, 0);
        check(ras_n && cas_n && !busy, "R1 strobes", {ras_n, cas_n, busy}, 3'b110);
    endtask

    task automatic t_regs();
        logic [7:0] d;
        wr(2'd1, 8'hA5); rd(2'd1, d); check(d == 8'hA5, "R6 compare readback", d, 8'hA5);
        wr(2'd2, 8'h3B); rd(2'd2, d); check(d == 8'h3B, "R6 control readback", d, 8'h3B);
        rd(2'd3, d); check(d == 0, "R6 unused address", d, 0);
        wr(2'd2, 8'h00);
    endtask

    task automatic t_stopped();
        logic [7:0] d;
        int base;
        wr(2'd1, 8'd3);
        wr(2'd0, 8'd7);
        base = cas_falls;
        repeat (50) @(negedge clk);
        rd(2'd0, d); check(d == 7, "R2 counter holds", d, 7);
        check(cas_falls == base, "R2 no refresh", cas_falls - base, 0);
    endtask

    task automatic t_count();
        logic [7:0] d;
        setup(8'd5, 8'd200, 8'h01);
        repeat (19) @(negedge clk);
        rd(2'd0, d); check(d == 15, "R3 ten steps from 5", d, 15);
        wr(2'd0, 8'd100);
        rd(2'd0, d); check(d == 100, "R3 write priority", d, 100);
    endtask

    task automatic t_wrap();
        int n;
        setup(8'd250, 8'd3, 8'h01);
        wait_rise(n);
        check(n >= 18 && n <= 22, "R5 wrap before match", n, 20);
    endtask

    task automatic t_interval(input logic [7:0] code, input logic [7:0] cmp, input int exp);
        int n;
        setup(8'd0, cmp, code);
        wait_rise(n);
        wait_rise(n);
        check(n == exp, "R4 interval", n, exp);
    endtask

    task automatic t_sequence();
        int n;
        logic [7:0] d;
        setup(8'd0, 8'd9, 8'h01);
        wait_rise(n);
        rd(2'd0, d); check(d == 0, "R4 counter cleared", d, 0);
        check(ras_n && cas_n, "R7 precharge", {ras_n, cas_n}, 2'b11);
        @(negedge clk); check(ras_n && !cas_n, "R7 cas first", {ras_n, cas_n}, 2'b10);
        @(negedge clk); check(!ras_n && !cas_n, "R7 both low", {ras_n, cas_n}, 2'b00);
        @(negedge clk); check(ras_n && cas_n && busy, "R7 completion", {ras_n, cas_n, busy}, 3'b111);
        @(negedge clk); check(!busy, "R10 busy ends", busy, 0);
    endtask

    task automatic t_waits();
        int n, b, r, c;
        setup(8'd0, 8'd9, 8'h29);
        wait_rise(n);
        measure(b, r, c);
        check(b == 6, "R10 busy length two waits", b, 6);
        check(r == 3, "R8 ras low two waits", r, 3);
        check(c == 4, "R8 cas low two waits", c, 4);
        wr(2'd2, 8'h31);
        wait_rise(n);
        measure(b, r, c);
        check(b == 4, "R8 long-pitch off busy", b, 4);
        check(r == 1, "R8 long-pitch off ras", r, 1);
    endtask

    task automatic t_pending();
        int n, base;
        bit solid;
        setup(8'd0, 8'd0, 8'h39);
        wait_rise(n);
        solid = 1'b1;
        repeat (40) begin
            @(negedge clk);
            if (!busy) solid = 1'b0;
        end
        check(solid, "R9 back-to-back", solid, 1);
        wr(2'd2, 8'h38);
        base = cas_falls;
        repeat (30) @(negedge clk);
        check((cas_falls - base) >= 1 && (cas_falls - base) <= 2, "R9 one pending only",
              cas_falls - base, 2);
        check(!busy, "R9 idle after drain", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_regs();
        t_stopped();
        t_count();
        t_wrap();
        t_interval(8'h01, 8'd9, 20);
        t_interval(8'h02, 8'd4, 40);
        t_interval(8'h03, 8'd1, 64);
        t_interval(8'h07, 8'd0, 4096);
        t_sequence();
        t_waits();
        t_pending();
        summary();
    end

endmodule